// File: doc/BRIEF.md
# Ternary-Select Output Clock Divider

This block takes the nominal-frequency clock and produces a slower clock whose period is a whole number of input cycles. The number is set by two three-level select inputs rather than a binary word. The nine combinations give the ratios 1, 2, 3, 4, 5, 6, 8, 10 and 12. The same divider is placed once for each of the four output banks and once for the feedback bank. Every instance has its own active-high disable, which holds its output low.

Even ratios give an exact half-period high time. Odd ratios stretch the high phase by half an input cycle with a register clocked on the falling edge, so their high time is also half the period. Ratio 1 gates the input clock itself. A new ratio takes effect only at the end of the divided period in progress. A period-start flag marks the input cycle in which each divided period begins.

Top module: `tsd_clk_divider`

## Requirements
- R1: Each select is a 2-bit code: 00 is LOW, 01 is MID and 10 is HIGH. Taking `sel_hi_i` as the first digit and `sel_lo_i` as the second, the pairs LL, LM, LH, ML, MM, MH, HL, HM and HH select divide-by 1, 2, 3, 4, 5, 6, 8, 10 and 12.
- R2: The select code 11 behaves exactly like 01 (MID) on either select.
- R3: While enabled at a settled ratio N, successive rising edges of `clk_o` are exactly N input clock periods apart.
- R4: The high time of `clk_o` is N/2 input periods for every ratio. For odd N, 1 included, this is a half-period multiple.
- R5: Once `dis_i` is sampled high at a rising input edge, `start_o` is low after that edge. `clk_o` is low from the next falling input edge and stays low while `dis_i` remains high.
- R6: At the first rising input edge that samples `dis_i` low after a disable, a new period starts: `clk_o` rises and `start_o` goes high.
- R7: A change of the selects during a divided period leaves that period's length unchanged. The new ratio applies from the next period.
- R8: For N of 2 or more, `start_o` is high for exactly one input cycle per divided period, during the cycle in which `clk_o` rose. At ratio 1 it stays high while enabled.
- R9: While `rst_n` is low (synchronous, active low), `clk_o` and `start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nominal-frequency input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_hi_i | input | 2 | First three-level ratio select |
| sel_lo_i | input | 2 | Second three-level ratio select |
| dis_i | input | 1 | Output disable, active high |
| clk_o | output | 1 | Divided clock |
| start_o | output | 1 | High in the input cycle that begins a divided period |

## Verification
All sixteen select code pairs are applied in turn, including every pair that uses the 11 code. For each pair the period and the high time are measured from edge timestamps. The even, odd and unity ratios each take a different path to the output, so these measurements show which path is broken, and the 11 pairs show whether an unused code is mapped to MID or falls through to another level. Directed sequences then cover the remaining cases: holding the output off, restarting it, switching from ratio 12 to ratio 2 partway through a period, and counting start pulses at ratio 4. These separate a ratio that changes too early from one that changes at the period boundary, and a restart that begins a fresh period from one that resumes the old count.

// File: rtl/tsd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the ternary-select clock divider.
// Assumes the select encoding 00=LOW, 01=MID, 10=HIGH, with 11 read as MID.
package tsd_pkg;

    parameter int RATIO_W = 4;   // wide enough for the largest ratio (12)
    parameter int N_SEL   = 2;   // number of three-level selects

    typedef logic [RATIO_W-1:0] ratio_t;

    // Map a 2-bit select code to its level index 0..2.
    function automatic logic [1:0] level_of(input logic [1:0] code);
        case (code)
            2'b00:   level_of = 2'd0;
            2'b10:   level_of = 2'd2;
            default: level_of = 2'd1;
        endcase
    endfunction

    // Map the combined index (first*3 + second) to its divide ratio.
    function automatic ratio_t ratio_of(input logic [3:0] idx);
        case (idx)
            4'd0:    ratio_of = ratio_t'(1);
            4'd1:    ratio_of = ratio_t'(2);
            4'd2:    ratio_of = ratio_t'(3);
            4'd3:    ratio_of = ratio_t'(4);
            4'd4:    ratio_of = ratio_t'(5);
            4'd5:    ratio_of = ratio_t'(6);
            4'd6:    ratio_of = ratio_t'(8);
            4'd7:    ratio_of = ratio_t'(10);
            4'd8:    ratio_of = ratio_t'(12);
            default: ratio_of = ratio_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/tsd_sel_decode.sv
`timescale 1ns/1ps
// Select decoder: turns the two three-level select codes into a divide ratio.
// Purely combinational; the caller decides when the result is applied.
module tsd_sel_decode
    import tsd_pkg::*;
#(
    parameter int RW = tsd_pkg::RATIO_W
) (
    input  logic [1:0]    sel_hi_i,
    input  logic [1:0]    sel_lo_i,
    output logic [RW-1:0] ratio_o
);

    logic [1:0] codes [N_SEL];
    logic [1:0] lvls  [N_SEL];
    logic [3:0] idx;

    assign codes[0] = sel_lo_i;
    assign codes[1] = sel_hi_i;

    // Convert each select code to a level index.
    for (genvar g = 0; g < N_SEL; g++) begin : g_lvl
        assign lvls[g] = level_of(codes[g]);
    end

    // Combine the two levels into one index and look up the ratio.
    always_comb begin
        idx     = 4'(lvls[1]) * 4'd3 + 4'(lvls[0]);
        ratio_o = RW'(ratio_of(idx));
    end

endmodule

// File: rtl/tsd_period_gen.sv
`timescale 1ns/1ps
// Period generator: counts input cycles inside a divided period, loads a new
// ratio only at a period boundary, and produces the rising-edge high phase
// and the period-start flag.
// Assumes: ratio_req_i is never 0; the high phase lasts floor(N/2) cycles.
module tsd_period_gen #(
    parameter int RW = tsd_pkg::RATIO_W
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          dis_i,
    input  logic [RW-1:0] ratio_req_i,
    output logic          run_o,
    output logic [RW-1:0] ratio_act_o,
    output logic          hi_pos_o,
    output logic          start_o
);

    logic          run_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] ratio_q;
    logic          hi_q;
    logic          start_q;

    logic          wrap;
    logic [RW-1:0] cnt_nxt;
    logic [RW-1:0] half_req;
    logic [RW-1:0] half_act;

    // Decide whether the next rising edge begins a fresh period.
    always_comb begin
        half_req = ratio_req_i >> 1;
        half_act = ratio_q >> 1;
        cnt_nxt  = cnt_q + RW'(1);
        wrap     = !run_q || (cnt_q == ratio_q - RW'(1));
    end

    // Advance the cycle count, reload the ratio at the boundary, set outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_n || dis_i) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            ratio_q <= ratio_req_i;
            hi_q    <= 1'b0;
            start_q <= 1'b0;
        end else if (wrap) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            ratio_q <= ratio_req_i;
            hi_q    <= (half_req != '0);
            start_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_nxt;
            hi_q    <= (cnt_nxt < half_act);
            start_q <= 1'b0;
        end
    end

    assign run_o       = run_q;
    assign ratio_act_o = ratio_q;
    assign hi_pos_o    = hi_q;
    assign start_o     = start_q;

endmodule

// File: rtl/tsd_phase_ext.sv
`timescale 1ns/1ps
// Output shaper: for odd ratios, ORs a falling-edge copy of the high phase into
// the output to add half an input cycle; for ratio 1 it gates the input clock.
// Assumes the high phase comes from a rising-edge register of the same clock.
module tsd_phase_ext #(
    parameter int RW = tsd_pkg::RATIO_W
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          hi_pos_i,
    input  logic [RW-1:0] ratio_act_i,
    output logic          clk_o
);

    logic ext_q;
    logic odd;
    logic unity;

    // Delay the high phase by half an input cycle on the falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= hi_pos_i;
    end

    // Choose the output path for the active ratio.
    always_comb begin
        odd   = ratio_act_i[0];
        unity = (ratio_act_i == RW'(1));
        if (unity) clk_o = clk_i & run_i;
        else       clk_o = hi_pos_i | (odd & ext_q);
    end

endmodule

// File: rtl/tsd_clk_divider.sv
`timescale 1ns/1ps
// Ternary-select clock divider top: decoder, period generator and output shaper.
// Assumes one instance per bank; all inputs are synchronous to clk_i.
module tsd_clk_divider #(
    parameter int RW = tsd_pkg::RATIO_W
) (
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic [1:0] sel_hi_i,
    input  logic [1:0] sel_lo_i,
    input  logic       dis_i,
    output logic       clk_o,
    output logic       start_o
);

    logic [RW-1:0] ratio_req;
    logic [RW-1:0] ratio_act;
    logic          run;
    logic          hi_pos;

    tsd_sel_decode #(.RW(RW)) u_dec (
        .sel_hi_i (sel_hi_i),
        .sel_lo_i (sel_lo_i),
        .ratio_o  (ratio_req)
    );

    tsd_period_gen #(.RW(RW)) u_per (
        .clk_i       (clk_i),
        .rst_n       (rst_n),
        .dis_i       (dis_i),
        .ratio_req_i (ratio_req),
        .run_o       (run),
        .ratio_act_o (ratio_act),
        .hi_pos_o    (hi_pos),
        .start_o     (start_o)
    );

    tsd_phase_ext #(.RW(RW)) u_ext (
        .clk_i       (clk_i),
        .rst_n       (rst_n),
        .run_i       (run),
        .hi_pos_i    (hi_pos),
        .ratio_act_i (ratio_act),
        .clk_o       (clk_o)
    );

endmodule

// File: rtl/tsd_clk_divider_chk.sv
`timescale 1ns/1ps
// Protocol checker for tsd_clk_divider, attached with bind.
module tsd_clk_divider_chk #(
    parameter int RW = tsd_pkg::RATIO_W
) (
    input logic          clk_i,
    input logic          rst_n,
    input logic          dis_i,
    input logic          clk_o,
    input logic          start_o,
    input logic [RW-1:0] ratio_act
);

    // R5
    dis_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        dis_i |=> !start_o);

    // R5
    dis_out_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (dis_i && $past(dis_i)) |-> !clk_o);

    // R6
    reen_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(dis_i) |=> start_o);

    // R8
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (start_o && ratio_act != RW'(1)) |=> !start_o);

    // R9
    rst_start_chk: assert property (@(posedge clk_i)
        !rst_n |=> !start_o);

endmodule

bind tsd_clk_divider tsd_clk_divider_chk #(.RW(RW)) u_chk (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .dis_i     (dis_i),
    .clk_o     (clk_o),
    .start_o   (start_o),
    .ratio_act (ratio_act)
);

// File: tb/test_tsd_clk_divider.sv
`timescale 1ns/1ps
module test_tsd_clk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_hi = 2'b00;
    logic [1:0] sel_lo = 2'b00;
    logic       dis = 1'b0;
    logic       clk_o;
    logic       start_o;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct { int ratio; string tag; } exp_t;
    exp_t exp_q[$];

    int ratio_tab [9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};

    always #4 clk = ~clk;

    tsd_clk_divider i_tsd_clk_divider (
        .clk_i    (clk),
        .rst_n    (rst_n),
        .sel_hi_i (sel_hi),
        .sel_lo_i (sel_lo),
        .dis_i    (dis),
        .clk_o    (clk_o),
        .start_o  (start_o)
    );

    function automatic int lvl(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 2;
        return 1;
    endfunction

    function automatic bit near(input real a, input real b);
        return ((a - b) < 0.01) && ((b - a) < 0.01);
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // Monitor: measures one full period and its high time, compares with the queue head.
    initial begin
        real tr, tf, t2;
        exp_t e;
        forever begin
            @(posedge clk_o); tr = $realtime;
            @(negedge clk_o); tf = $realtime;
            @(posedge clk_o); t2 = $realtime;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(near(t2 - tr, 8.0 * e.ratio), {e.tag, " R3 period"},
                      $sformatf("%0.3f", t2 - tr), $sformatf("%0.3f", 8.0 * e.ratio));
                check(near(tf - tr, 4.0 * e.ratio), {e.tag, " R4 high"},
                      $sformatf("%0.3f", tf - tr), $sformatf("%0.3f", 4.0 * e.ratio));
            end
        end
    end

    // Driver: applies a select pair, waits for it to settle, queues expectations.
    task automatic drive_code(input logic [1:0] h, input logic [1:0] l);
        int r;
        string tag;
        @(negedge clk);
        sel_hi = h;
        sel_lo = l;
        r = ratio_tab[lvl(h) * 3 + lvl(l)];
        tag = ((h == 2'b11) || (l == 2'b11)) ?
              $sformatf("R1 R2 code %b/%b", h, l) : $sformatf("R1 code %b/%b", h, l);
        repeat (3) @(posedge clk_o);
        #1;
        exp_q.push_back('{ratio: r, tag: tag});
        exp_q.push_back('{ratio: r, tag: tag});
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        real t0, t1, t2;
        int starts, mism;
        // R9: reset state, sampled in both clock phases
        repeat (3) begin
            @(posedge clk); #2;
            check(clk_o == 1'b0 && start_o == 1'b0, "R9 reset high phase",
                  $sformatf("%b%b", clk_o, start_o), "00");
            @(negedge clk); #2;
            check(clk_o == 1'b0 && start_o == 1'b0, "R9 reset low phase",
                  $sformatf("%b%b", clk_o, start_o), "00");
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4: sweep every select pair
        for (int h = 0; h < 4; h++)
            for (int l = 0; l < 4; l++)
                drive_code(2'(h), 2'(l));

        // R5: disable at ratio 3 holds outputs low
        drive_code(2'b00, 2'b10);
        @(negedge clk); dis = 1'b1;
        repeat (2) @(posedge clk);
        repeat (10) begin
            @(posedge clk); #2;
            check(clk_o == 1'b0 && start_o == 1'b0, "R5 disabled high phase",
                  $sformatf("%b%b", clk_o, start_o), "00");
            @(negedge clk); #2;
            check(clk_o == 1'b0 && start_o == 1'b0, "R5 disabled low phase",
                  $sformatf("%b%b", clk_o, start_o), "00");
        end

        // R6: re-enable at ratio 12 starts a new period at once
        @(negedge clk); sel_hi = 2'b10; sel_lo = 2'b10;
        @(negedge clk); dis = 1'b0;
        @(posedge clk); t0 = $realtime; #2;
        check(clk_o == 1'b1 && start_o == 1'b1, "R6 restart",
              $sformatf("%b%b", clk_o, start_o), "11");
        @(posedge clk); #2;
        check(start_o == 1'b0, "R8 single start cycle", $sformatf("%b", start_o), "0");

        // R7: change to ratio 2 mid-period; current period stays 12 cycles
        repeat (2) @(negedge clk);
        sel_hi = 2'b00; sel_lo = 2'b01;
        @(posedge clk_o); t1 = $realtime;
        check(near(t1 - t0, 96.0), "R7 period kept",
              $sformatf("%0.3f", t1 - t0), "96.000");
        @(posedge clk_o); t2 = $realtime;
        check(near(t2 - t1, 16.0), "R7 new ratio next period",
              $sformatf("%0.3f", t2 - t1), "16.000");

        // R8: ratio 4, count start pulses over 24 cycles
        drive_code(2'b01, 2'b00);
        starts = 0; mism = 0;
        repeat (24) begin
            @(posedge clk); #2;
            if (start_o) starts++;
            if (start_o && !clk_o) mism++;
        end
        check(starts == 6, "R8 start count", $sformatf("%0d", starts), "6");
        check(mism == 0, "R8 start aligned to rise", $sformatf("%0d", mism), "0");

        finish_run();
    end

endmodule